// File: doc/BRIEF.md
# Flash Command Reset Sequencer

This controller sits between a microcontroller write/read bus and a flash array model. It decodes bus write strobes into array commands, including a reset command that the bus may issue either as a single bare write or after a two-write unlock prefix. It keeps track of the array mode: normal read, identifier read, program, bulk erase, sector erase, error and post-reset recovery. Program and erase are modelled as fixed-length busy periods, and a one-cycle failure input ends an operation in the error state.

The reset command acts in one of three ways, depending on the current mode. It is ignored while a program or bulk erase runs. It aborts a sector erase. It clears an error. An abort or a cleared error passes through a recovery period of a fixed number of clock cycles, and that period stands for the bounded delay needed to return to read mode. An external abort input forces any busy mode into the same recovery period. Until the array is back in read mode, the read data port carries a status byte instead of array data, and the ready output stays low.

Top module: `flash_rst_seq`

## Requirements
- R1: After the synchronous reset, `mode` is 0 (read), `ready` is 1 and `rdata` equals `array_rdata`.
- R2: The prefix AAh written at address 555h, then 55h written at address AAAh, followed by command byte 90h, moves the block to mode 1 (identifier read). In that mode `rdata` equals `ident_rdata` and `ready` is 1. The block stays in mode 1 until a reset command arrives.
- R3: A reset command is a write of data F0h. It is accepted at any address with no prefix, and it is also accepted as the command byte after the unlock prefix. Either form returns the block from mode 1 to mode 0 on the next cycle.
- R4: A write that breaks the unlock prefix (wrong data or wrong address) returns the decoder to idle. A following command byte then has no effect.
- R5: When the block is in mode 0, the command byte after the prefix starts an operation. A0h gives program (mode 2) for PROG_CYCLES cycles, 10h gives bulk erase (mode 3) for BULK_CYCLES cycles, and 30h gives sector erase (mode 4) for SECT_CYCLES cycles. The block then returns to mode 0.
- R6: A reset command in mode 2 or mode 3 is ignored, and the operation finishes after its full length.
- R7: A reset command in mode 4 aborts the erase. The block enters recovery (mode 6) for exactly RECOVER_CYCLES cycles and then goes to mode 0.
- R8: `op_fail` high in mode 2, 3 or 4 moves the block to error (mode 5). Only a reset command or an external abort leaves mode 5, and other commands are ignored there.
- R9: A reset command in mode 5 starts recovery (mode 6) for exactly RECOVER_CYCLES cycles, followed by mode 0.
- R10: `ext_abort` high in modes 2 to 6 moves the block to mode 6 and restarts the full recovery count. In mode 0 or 1 it gives mode 0 on the next cycle.
- R11: In modes 2 to 6, `ready` is 0 and `rdata` is a status byte. Bit 5 of that byte is the error flag, so the byte is 20h in mode 5 and 00h otherwise.
- R12: In mode 1, operation commands are ignored. In mode 6, a reset command is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | One-cycle write strobe |
| bus_addr | input | ADDR_W | Write address |
| bus_wdata | input | 8 | Write data byte |
| ext_abort | input | 1 | External abort pulse |
| op_fail | input | 1 | Failure report from the array model |
| array_rdata | input | 8 | Array data for normal read |
| ident_rdata | input | 8 | Identifier/protection data |
| rdata | output | 8 | Read data or status byte |
| ready | output | 1 | High in read and identifier modes |
| mode | output | 3 | Current array mode code |

## Verification
The reset command is applied in every mode, in both its bare and its prefixed form. This shows which modes honour it, which ignore it and which go through recovery. Each busy period is timed to the cycle, both with and without a reset written part way through. Because of this, an ignored reset that cut the period short, or a recovery period of the wrong length, shows up as a count mismatch. The external abort is applied in identifier mode, in bulk erase and part way through recovery. This separates the immediate return to read mode, the forced recovery and the restarted count. Broken unlock prefixes and operation commands sent in identifier and error modes confirm that only well-formed sequences reach the mode logic.

// File: rtl/frs_pkg.sv
package frs_pkg;

    typedef enum logic [2:0] {
        MODE_READ    = 3'd0,
        MODE_IDENT   = 3'd1,
        MODE_PROG    = 3'd2,
        MODE_BULK    = 3'd3,
        MODE_SECT    = 3'd4,
        MODE_ERROR   = 3'd5,
        MODE_RECOVER = 3'd6
    } mode_e;

    typedef enum logic [2:0] {
        CMD_NONE,
        CMD_RESET,
        CMD_IDENT,
        CMD_PROG,
        CMD_BULK,
        CMD_SECT
    } cmd_e;

    typedef enum logic [1:0] {
        UNL_IDLE,
        UNL_FIRST,
        UNL_SECOND
    } unlock_e;

    localparam logic [7:0]  KEY_FIRST  = 8'hAA;
    localparam logic [7:0]  KEY_SECOND = 8'h55;
    localparam logic [11:0] ADR_FIRST  = 12'h555;
    localparam logic [11:0] ADR_SECOND = 12'hAAA;
    localparam logic [7:0]  BYTE_RESET = 8'hF0;
    localparam logic [7:0]  BYTE_IDENT = 8'h90;
    localparam logic [7:0]  BYTE_PROG  = 8'hA0;
    localparam logic [7:0]  BYTE_BULK  = 8'h10;
    localparam logic [7:0]  BYTE_SECT  = 8'h30;
    localparam int          ERR_BIT    = 5;

    function automatic cmd_e decode_cmd(logic [7:0] b);
        case (b)
            BYTE_RESET: return CMD_RESET;
            BYTE_IDENT: return CMD_IDENT;
            BYTE_PROG:  return CMD_PROG;
            BYTE_BULK:  return CMD_BULK;
            BYTE_SECT:  return CMD_SECT;
            default:    return CMD_NONE;
        endcase
    endfunction

    function automatic logic mode_busy(mode_e m);
        return !(m == MODE_READ || m == MODE_IDENT);
    endfunction

    function automatic logic [7:0] status_byte(mode_e m);
        logic [7:0] s;
        s = '0;
        s[ERR_BIT] = (m == MODE_ERROR);
        return s;
    endfunction

endpackage

// File: rtl/frs_cmd_decode.sv
module frs_cmd_decode
    import frs_pkg::*;
#(
    parameter int ADDR_W = 12
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        wdata,
    output cmd_e              cmd
);

    localparam logic [ADDR_W-1:0] A1 = ADDR_W'(ADR_FIRST);
    localparam logic [ADDR_W-1:0] A2 = ADDR_W'(ADR_SECOND);

    unlock_e st_q, st_d;

    always_comb begin
        st_d = st_q;
        cmd  = CMD_NONE;
        if (wr) begin
            st_d = UNL_IDLE;
            if (wdata == BYTE_RESET) begin
                cmd = CMD_RESET;
            end else begin
                case (st_q)
                    UNL_IDLE:   if (wdata == KEY_FIRST && addr == A1) st_d = UNL_FIRST;
                    UNL_FIRST:  if (wdata == KEY_SECOND && addr == A2) st_d = UNL_SECOND;
                    UNL_SECOND: cmd = decode_cmd(wdata);
                    default:    st_d = UNL_IDLE;
                endcase
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= UNL_IDLE;
        else     st_q <= st_d;
    end

endmodule

// File: rtl/frs_op_timer.sv
module frs_op_timer #(
    parameter int CNT_W = 12
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CNT_W-1:0] val,
    output logic             zero
);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst)                cnt_q <= '0;
        else if (load)          cnt_q <= val;
        else if (cnt_q != '0)   cnt_q <= cnt_q - CNT_W'(1);
    end

    assign zero = (cnt_q == '0);

endmodule

// File: rtl/frs_mode_ctrl.sv
module frs_mode_ctrl
    import frs_pkg::*;
#(
    parameter int PROG_CYCLES    = 40,
    parameter int BULK_CYCLES    = 200,
    parameter int SECT_CYCLES    = 120,
    parameter int RECOVER_CYCLES = 3125,
    parameter int CNT_W          = 12
) (
    input  logic             clk,
    input  logic             rst,
    input  cmd_e             cmd,
    input  logic             ext_abort,
    input  logic             op_fail,
    input  logic             tmr_zero,
    output mode_e            mode,
    output logic             tmr_load,
    output logic [CNT_W-1:0] tmr_val
);

    localparam logic [CNT_W-1:0] LD_PROG = CNT_W'(PROG_CYCLES - 1);
    localparam logic [CNT_W-1:0] LD_BULK = CNT_W'(BULK_CYCLES - 1);
    localparam logic [CNT_W-1:0] LD_SECT = CNT_W'(SECT_CYCLES - 1);
    localparam logic [CNT_W-1:0] LD_REC  = CNT_W'(RECOVER_CYCLES - 1);

    mode_e mode_d;

    always_comb begin
        mode_d   = mode;
        tmr_load = 1'b0;
        tmr_val  = '0;
        if (ext_abort) begin
            if (mode_busy(mode)) begin
                mode_d   = MODE_RECOVER;
                tmr_load = 1'b1;
                tmr_val  = LD_REC;
            end else begin
                mode_d = MODE_READ;
            end
        end else begin
            case (mode)
                MODE_READ: begin
                    case (cmd)
                        CMD_IDENT: mode_d = MODE_IDENT;
                        CMD_PROG: begin
                            mode_d = MODE_PROG; tmr_load = 1'b1; tmr_val = LD_PROG;
                        end
                        CMD_BULK: begin
                            mode_d = MODE_BULK; tmr_load = 1'b1; tmr_val = LD_BULK;
                        end
                        CMD_SECT: begin
                            mode_d = MODE_SECT; tmr_load = 1'b1; tmr_val = LD_SECT;
                        end
                        default: mode_d = MODE_READ;
                    endcase
                end
                MODE_IDENT: if (cmd == CMD_RESET) mode_d = MODE_READ;
                MODE_PROG, MODE_BULK: begin
                    if (op_fail)       mode_d = MODE_ERROR;
                    else if (tmr_zero) mode_d = MODE_READ;
                end
                MODE_SECT: begin
                    if (cmd == CMD_RESET) begin
                        mode_d = MODE_RECOVER; tmr_load = 1'b1; tmr_val = LD_REC;
                    end else if (op_fail) begin
                        mode_d = MODE_ERROR;
                    end else if (tmr_zero) begin
                        mode_d = MODE_READ;
                    end
                end
                MODE_ERROR: begin
                    if (cmd == CMD_RESET) begin
                        mode_d = MODE_RECOVER; tmr_load = 1'b1; tmr_val = LD_REC;
                    end
                end
                MODE_RECOVER: if (tmr_zero) mode_d = MODE_READ;
                default: mode_d = MODE_READ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) mode <= MODE_READ;
        else     mode <= mode_d;
    end

endmodule

// File: rtl/flash_rst_seq.sv
module flash_rst_seq
    import frs_pkg::*;
#(
    parameter int ADDR_W         = 12,
    parameter int PROG_CYCLES    = 40,
    parameter int BULK_CYCLES    = 200,
    parameter int SECT_CYCLES    = 120,
    parameter int RECOVER_CYCLES = 3125
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [7:0]        bus_wdata,
    input  logic              ext_abort,
    input  logic              op_fail,
    input  logic [7:0]        array_rdata,
    input  logic [7:0]        ident_rdata,
    output logic [7:0]        rdata,
    output logic              ready,
    output logic [2:0]        mode
);

    localparam int MAX_OP    = (BULK_CYCLES > SECT_CYCLES) ?
                               ((BULK_CYCLES > PROG_CYCLES) ? BULK_CYCLES : PROG_CYCLES) :
                               ((SECT_CYCLES > PROG_CYCLES) ? SECT_CYCLES : PROG_CYCLES);
    localparam int MAX_CYC   = (MAX_OP > RECOVER_CYCLES) ? MAX_OP : RECOVER_CYCLES;
    localparam int CNT_W     = $clog2(MAX_CYC + 1);

    cmd_e             dec_cmd;
    mode_e            mode_q;
    logic             tmr_load;
    logic [CNT_W-1:0] tmr_val;
    logic             tmr_zero;

    frs_cmd_decode #(.ADDR_W(ADDR_W)) u_decode (
        .clk   (clk),
        .rst   (rst),
        .wr    (bus_wr),
        .addr  (bus_addr),
        .wdata (bus_wdata),
        .cmd   (dec_cmd)
    );

    frs_op_timer #(.CNT_W(CNT_W)) u_timer (
        .clk  (clk),
        .rst  (rst),
        .load (tmr_load),
        .val  (tmr_val),
        .zero (tmr_zero)
    );

    frs_mode_ctrl #(
        .PROG_CYCLES    (PROG_CYCLES),
        .BULK_CYCLES    (BULK_CYCLES),
        .SECT_CYCLES    (SECT_CYCLES),
        .RECOVER_CYCLES (RECOVER_CYCLES),
        .CNT_W          (CNT_W)
    ) u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .cmd       (dec_cmd),
        .ext_abort (ext_abort),
        .op_fail   (op_fail),
        .tmr_zero  (tmr_zero),
        .mode      (mode_q),
        .tmr_load  (tmr_load),
        .tmr_val   (tmr_val)
    );

    always_comb begin
        case (mode_q)
            MODE_READ:  rdata = array_rdata;
            MODE_IDENT: rdata = ident_rdata;
            default:    rdata = status_byte(mode_q);
        endcase
    end

    assign ready = !mode_busy(mode_q);
    assign mode  = mode_q;

endmodule

// File: rtl/frs_checker.sv
module frs_checker
    import frs_pkg::*;
#(
    parameter int RECOVER_CYCLES = 3125
) (
    input logic       clk,
    input logic       rst,
    input mode_e      mode_q,
    input cmd_e       dec_cmd,
    input logic       ext_abort,
    input logic       op_fail,
    input logic       tmr_zero,
    input logic       ready,
    input logic [7:0] rdata
);

    localparam int RC_W = $clog2(RECOVER_CYCLES + 1) + 1;

    logic [RC_W-1:0] rc_q;

    always_ff @(posedge clk) begin
        if (rst)                        rc_q <= '0;
        else if (mode_q != MODE_RECOVER) rc_q <= '0;
        else if (ext_abort)             rc_q <= '0;
        else                            rc_q <= rc_q + RC_W'(1);
    end

    AST_IDENT_HOLD: assert property (@(posedge clk) disable iff (rst)
        (mode_q == MODE_IDENT && dec_cmd != CMD_RESET && !ext_abort) |=> (mode_q == MODE_IDENT)); // R2

    AST_PROG_IGNORES_RESET: assert property (@(posedge clk) disable iff (rst)
        (mode_q == MODE_PROG && dec_cmd == CMD_RESET && !ext_abort && !op_fail && !tmr_zero)
        |=> (mode_q == MODE_PROG)); // R6

    AST_SECT_ABORT: assert property (@(posedge clk) disable iff (rst)
        (mode_q == MODE_SECT && dec_cmd == CMD_RESET && !ext_abort) |=> (mode_q == MODE_RECOVER)); // R7

    AST_RECOVER_BOUND: assert property (@(posedge clk) disable iff (rst)
        (mode_q == MODE_RECOVER) |-> (rc_q < RC_W'(RECOVER_CYCLES))); // R7

    AST_ERROR_HOLD: assert property (@(posedge clk) disable iff (rst)
        (mode_q == MODE_ERROR && dec_cmd != CMD_RESET && !ext_abort) |=> (mode_q == MODE_ERROR)); // R8

    AST_EXT_ABORT_BUSY: assert property (@(posedge clk) disable iff (rst)
        (ext_abort && mode_q != MODE_READ && mode_q != MODE_IDENT) |=> (mode_q == MODE_RECOVER)); // R10

    AST_EXT_ABORT_IDLE: assert property (@(posedge clk) disable iff (rst)
        (ext_abort && (mode_q == MODE_READ || mode_q == MODE_IDENT)) |=> (mode_q == MODE_READ)); // R10

    AST_ERROR_STATUS: assert property (@(posedge clk) disable iff (rst)
        (mode_q == MODE_ERROR) |-> (!ready && rdata == 8'h20)); // R11

endmodule

bind flash_rst_seq frs_checker #(.RECOVER_CYCLES(RECOVER_CYCLES)) u_frs_checker (
    .clk       (clk),
    .rst       (rst),
    .mode_q    (mode_q),
    .dec_cmd   (dec_cmd),
    .ext_abort (ext_abort),
    .op_fail   (op_fail),
    .tmr_zero  (tmr_zero),
    .ready     (ready),
    .rdata     (rdata)
);

// File: tb/test_flash_rst_seq.sv
`timescale 1ns/1ps
module test_flash_rst_seq;

    localparam int AW    = 12;
    localparam int T_PRG = 40;
    localparam int T_BLK = 200;
    localparam int T_SEC = 120;
    localparam int T_REC = 3125;

    localparam logic [2:0] M_READ = 3'd0, M_IDENT = 3'd1, M_PROG = 3'd2,
                           M_BULK = 3'd3, M_SECT = 3'd4, M_ERR = 3'd5, M_REC = 3'd6;
    localparam logic [7:0] ARR_D = 8'h5A, ID_D = 8'hC3;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          bus_wr = 1'b0;
    logic [AW-1:0] bus_addr = '0;
    logic [7:0]    bus_wdata = '0;
    logic          ext_abort = 1'b0;
    logic          op_fail = 1'b0;
    logic [7:0]    array_rdata = ARR_D;
    logic [7:0]    ident_rdata = ID_D;
    logic [7:0]    rdata;
    logic          ready;
    logic [2:0]    mode;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    flash_rst_seq #(
        .ADDR_W(AW), .PROG_CYCLES(T_PRG), .BULK_CYCLES(T_BLK),
        .SECT_CYCLES(T_SEC), .RECOVER_CYCLES(T_REC)
    ) i_flash_rst_seq (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .ext_abort(ext_abort), .op_fail(op_fail),
        .array_rdata(array_rdata), .ident_rdata(ident_rdata),
        .rdata(rdata), .ready(ready), .mode(mode)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [AW-1:0] a, input logic [7:0] d);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk);
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic cmd_seq(input logic [7:0] c);
        wr(12'h555, 8'hAA);
        wr(12'hAAA, 8'h55);
        wr(12'h555, c);
    endtask

    task automatic pulse_abort();
        ext_abort = 1'b1;
        @(negedge clk);
        ext_abort = 1'b0;
    endtask

    task automatic pulse_fail();
        op_fail = 1'b1;
        @(negedge clk);
        op_fail = 1'b0;
    endtask

    task automatic stay_len(input logic [2:0] m, output int n);
        n = 0;
        while (mode == m && n < 20000) begin
            n++;
            @(negedge clk);
        end
    endtask

    task automatic t_reset_state();
        chk("R1 mode", mode, M_READ);
        chk("R1 ready", ready, 1);
        chk("R1 rdata", rdata, ARR_D);
    endtask

    task automatic t_ident_bare_reset();
        cmd_seq(8'h90);
        chk("R2 mode", mode, M_IDENT);
        chk("R2 rdata", rdata, ID_D);
        chk("R2 ready", ready, 1);
        repeat (20) @(negedge clk);
        chk("R2 hold", mode, M_IDENT);
        cmd_seq(8'hA0);
        chk("R12 op cmd in ident", mode, M_IDENT);
        wr(12'h123, 8'hF0);
        chk("R3 bare reset", mode, M_READ);
        chk("R3 rdata back", rdata, ARR_D);
    endtask

    task automatic t_ident_prefixed_reset();
        cmd_seq(8'h90);
        wr(12'h555, 8'hAA);
        wr(12'hAAA, 8'h55);
        chk("R3 mid prefix", mode, M_IDENT);
        wr(12'h555, 8'hF0);
        chk("R3 prefixed reset", mode, M_READ);
    endtask

    task automatic t_broken_unlock();
        wr(12'h555, 8'hAA);
        wr(12'h123, 8'h55);
        wr(12'h555, 8'h90);
        chk("R4 wrong address", mode, M_READ);
        wr(12'h555, 8'hAA);
        wr(12'hAAA, 8'h66);
        wr(12'h555, 8'h30);
        chk("R4 wrong data", mode, M_READ);
    endtask

    task automatic t_prog_ignore();
        int n;
        cmd_seq(8'hA0);
        chk("R5 prog mode", mode, M_PROG);
        chk("R11 prog ready", ready, 0);
        chk("R11 prog status", rdata, 8'h00);
        wr(12'h000, 8'hF0);
        chk("R6 prog after reset", mode, M_PROG);
        stay_len(M_PROG, n);
        chk("R6 prog full length", n, T_PRG - 1);
        chk("R5 prog done", mode, M_READ);
    endtask

    task automatic t_bulk_ignore();
        int n;
        cmd_seq(8'h10);
        chk("R5 bulk mode", mode, M_BULK);
        cmd_seq(8'hF0);
        chk("R6 bulk after reset", mode, M_BULK);
        stay_len(M_BULK, n);
        chk("R6 bulk full length", n, T_BLK - 3);
        chk("R5 bulk done", mode, M_READ);
    endtask

    task automatic t_sect_normal();
        int n;
        cmd_seq(8'h30);
        stay_len(M_SECT, n);
        chk("R5 sector length", n, T_SEC);
        chk("R5 sector done", mode, M_READ);
    endtask

    task automatic t_sect_abort();
        int n;
        cmd_seq(8'h30);
        repeat (5) @(negedge clk);
        wr(12'h0F0, 8'hF0);
        chk("R7 abort to recovery", mode, M_REC);
        chk("R11 recovery ready", ready, 0);
        chk("R11 recovery status", rdata, 8'h00);
        stay_len(M_REC, n);
        chk("R7 recovery length", n, T_REC);
        chk("R7 back to read", mode, M_READ);
    endtask

    task automatic t_error();
        int n;
        cmd_seq(8'hA0);
        pulse_fail();
        chk("R8 error mode", mode, M_ERR);
        chk("R11 error status", rdata, 8'h20);
        chk("R11 error ready", ready, 0);
        repeat (T_PRG + 20) @(negedge clk);
        chk("R8 error held", mode, M_ERR);
        cmd_seq(8'h90);
        chk("R8 cmd ignored in error", mode, M_ERR);
        wr(12'h3C5, 8'hF0);
        chk("R9 reset from error", mode, M_REC);
        stay_len(M_REC, n);
        chk("R9 recovery length", n, T_REC);
        chk("R9 back to read", mode, M_READ);
    endtask

    task automatic t_ext_abort();
        int n;
        cmd_seq(8'h90);
        pulse_abort();
        chk("R10 abort in ident", mode, M_READ);
        cmd_seq(8'h10);
        repeat (7) @(negedge clk);
        pulse_abort();
        chk("R10 abort in bulk", mode, M_REC);
        repeat (10) @(negedge clk);
        wr(12'h000, 8'hF0);
        chk("R12 reset in recovery", mode, M_REC);
        pulse_abort();
        chk("R10 abort in recovery", mode, M_REC);
        stay_len(M_REC, n);
        chk("R10 restarted length", n, T_REC);
        chk("R10 back to read", mode, M_READ);
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset_state();
        t_ident_bare_reset();
        t_ident_prefixed_reset();
        t_broken_unlock();
        t_prog_ignore();
        t_bulk_ignore();
        t_sect_normal();
        t_sect_abort();
        t_error();
        t_ext_abort();
        if (!done) finish_run();
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=running expected=finished");
            finish_run();
        end
    end

endmodule